// File: doc/BRIEF.md
# Staged Pipelined Unsigned Multiplier

This block is a long-latency arithmetic unit for a wide-instruction processor. It multiplies two 32-bit unsigned operands and returns the low 32 bits of the product. It accepts a new operand pair on any cycle. The work is spread over four registered stages. Each stage folds eight multiplier bits' worth of shifted multiplicand into a running sum and passes it forward. A result therefore appears exactly four cycles after its operands were issued.

The register that receives the result is not named when the operation is issued. A later instruction supplies it: the one that executes in the cycle the result retires. That instruction drives the destination index on `ret_dst`, and the block pairs it with the emerging product on `res_dst`, ready for a write port. The first stage register also acts as the interstage register that holds the operands. After the issue cycle, the operand inputs are free for other use.

Top module: `staged_mul32`

## Requirements
- R1: While `rst` is sampled high at a clock edge, and in the cycle that follows, `res_valid` is low. The synchronous reset clears the valid bit of every stage.
- R2: `res_data` equals the low 32 bits of the unsigned product of the issued operands. Product bits 32 to 63 are discarded, so 0xFFFFFFFF × 0xFFFFFFFF gives 0x00000001 and 0x00010000 × 0x00010000 gives 0.
- R3: An issue is a clock edge at which `in_valid` is high and `rst` is low. `res_valid` is high in the cycle that begins at the fourth clock edge after an issue. It is low in every cycle that no issue four edges earlier accounts for.
- R4: Operations may be issued on consecutive cycles with no bubble. Results then retire one per cycle, in issue order.
- R5: After stage k (k = 0..3), the running sum equals the multiplicand times the multiplier with only its bits 0 through 8k+7 kept, truncated to 32 bits. Each stage therefore adds exactly one byte of the multiplier.
- R6: While `res_valid` is high, `res_dst` equals the value on `ret_dst` in that same cycle. While `res_valid` is low, `res_dst` is zero.
- R7: Operations in flight when a reset edge occurs are discarded. None of them ever raises `res_valid`.
- R8: Operands are captured at issue. Changing `in_a` or `in_b` in later cycles, while `in_valid` is low, does not alter a result already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for the operand pair |
| in_a | input | 32 | Multiplicand |
| in_b | input | 32 | Multiplier |
| ret_dst | input | DST_W (6) | Destination index from the retiring instruction |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 32 | Low half of the product |
| res_dst | output | DST_W (6) | Destination paired with the result, zero when idle |

## Verification
The two events that share a cycle are the issue of a new operation and the retirement of one issued four cycles earlier. Once a stream runs longer than the pipeline depth, they coincide on every cycle. The bench provokes this with long back-to-back runs, with `ret_dst` changing every cycle and the operands changing on every issue. A delay-line model of its own predicts which cycles retire and what product each carries. Each retiring cycle is judged on three things: the result belongs to the issue four edges back and not to the one entering now, the destination is the one driven in that same cycle, and a reset edge in the middle of such a stream cancels every pending retirement.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int MW  = 32;
  localparam int SL  = 8;
  localparam int NST = MW / SL;

  typedef logic [MW-1:0] word_t;

  // Sum of the shifted multiplicand for the multiplier bits of lane k
  function automatic word_t pp_slice(input word_t a, input word_t b, input int k);
    word_t acc;
    acc = '0;
    for (int j = 0; j < SL; j++) begin
      if (b[k*SL + j]) acc = acc + (a << (k*SL + j));
    end
    return acc;
  endfunction

  // Low half of the full unsigned product
  function automatic word_t lo_product(input word_t a, input word_t b);
    logic [2*MW-1:0] full;
    full = {{MW{1'b0}}, a} * {{MW{1'b0}}, b};
    return full[MW-1:0];
  endfunction

  // Keep multiplier bits 0 .. SL*(k+1)-1
  function automatic word_t mask_low(input word_t b, input int k);
    word_t m;
    int n;
    n = (k + 1) * SL;
    if (n >= MW) m = '1;
    else         m = ~({MW{1'b1}} << n);
    return b & m;
  endfunction
endpackage

// File: rtl/mul_stage.sv
module mul_stage
  import smul_pkg::*;
#(
  parameter int K = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  v_i,
  input  word_t a_i,
  input  word_t b_i,
  input  word_t s_i,
  output logic  v_o,
  output word_t a_o,
  output word_t b_o,
  output word_t s_o
);
  word_t lane_sum;
  word_t next_sum;

  assign lane_sum = pp_slice(a_i, b_i, K);
  assign next_sum = s_i + lane_sum;

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    if (v_i) begin
      a_o <= a_i;
      b_o <= b_i;
      s_o <= next_sum;
    end
  end

  AST_STAGE_SUM: assert property (@(posedge clk) disable iff (rst)
    v_o |-> s_o == lo_product(a_o, mask_low(b_o, K))); // R5
endmodule

// File: rtl/retire_pair.sv
module retire_pair
  import smul_pkg::*;
#(
  parameter int DST_W = 6
) (
  input  logic             v_i,
  input  word_t            d_i,
  input  logic [DST_W-1:0] dst_i,
  output logic             res_valid,
  output word_t            res_data,
  output logic [DST_W-1:0] res_dst
);
  assign res_valid = v_i;
  assign res_data  = d_i;
  assign res_dst   = v_i ? dst_i : '0;
endmodule

// File: rtl/staged_mul32.sv
module staged_mul32
  import smul_pkg::*;
#(
  parameter int DST_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [MW-1:0]    in_a,
  input  logic [MW-1:0]    in_b,
  input  logic [DST_W-1:0] ret_dst,
  output logic             res_valid,
  output logic [MW-1:0]    res_data,
  output logic [DST_W-1:0] res_dst
);
  localparam int LAST = NST - 1;

  logic  v_d [NST];
  word_t a_d [NST];
  word_t b_d [NST];
  word_t s_d [NST];
  logic  v_q [NST];
  word_t a_q [NST];
  word_t b_q [NST];
  word_t s_q [NST];

  for (genvar k = 0; k < NST; k++) begin : g_st
    if (k == 0) begin : g_head
      assign v_d[k] = in_valid;
      assign a_d[k] = in_a;
      assign b_d[k] = in_b;
      assign s_d[k] = '0;
    end else begin : g_body
      assign v_d[k] = v_q[k-1];
      assign a_d[k] = a_q[k-1];
      assign b_d[k] = b_q[k-1];
      assign s_d[k] = s_q[k-1];
    end
    mul_stage #(.K(k)) u_st (
      .clk(clk), .rst(rst),
      .v_i(v_d[k]), .a_i(a_d[k]), .b_i(b_d[k]), .s_i(s_d[k]),
      .v_o(v_q[k]), .a_o(a_q[k]), .b_o(b_q[k]), .s_o(s_q[k])
    );
  end

  retire_pair #(.DST_W(DST_W)) u_ret (
    .v_i(v_q[LAST]), .d_i(s_q[LAST]), .dst_i(ret_dst),
    .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid, NST)); // R3
  AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_data == lo_product($past(in_a, NST), $past(in_b, NST))); // R8
  AST_TAIL_OPS: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_data == lo_product(a_q[LAST], b_q[LAST])); // R2
endmodule

// File: tb/sim_staged_mul32.sv
module sim_staged_mul32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [5:0]  ret_dst = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic [5:0]  res_dst;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit          mv [4];
  logic [31:0] mp [4];

  always #2 clk = ~clk;

  staged_mul32 #(.DST_W(6)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .ret_dst(ret_dst), .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst)
  );

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, check outputs before the edge, advance the model
  task automatic cyc(input logic r, input logic iv, input logic [31:0] a,
                     input logic [31:0] b, input logic [5:0] d, input string req);
    @(negedge clk);
    rst = r; in_valid = iv; in_a = a; in_b = b; ret_dst = d;
    #1;
    chk(req, {31'd0, res_valid}, {31'd0, mv[3]});
    if (mv[3]) begin
      chk(req, res_data, mp[3]);
      chk("R6", {26'd0, res_dst}, {26'd0, d});
    end else begin
      chk("R6", {26'd0, res_dst}, 32'd0);
    end
    for (int k = 3; k > 0; k--) begin
      mv[k] = mv[k-1];
      mp[k] = mp[k-1];
    end
    mv[0] = iv && !r;
    mp[0] = ref_mul(a, b);
    if (r) for (int k = 0; k < 4; k++) mv[k] = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 32'hDEAD0000 + i, 32'h0BAD0000 ^ i, 6'(i + 7), req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 32'h1234 + i, 32'h5678, 6'd5, "R1");
    cyc(1'b0, 1'b0, 32'h0, 32'h0, 6'd9, "R1");
  endtask

  task automatic t_single;
    cyc(1'b0, 1'b1, 32'd1234567, 32'd89, 6'd0, "R3");
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 32'h0, 32'h0, 6'(i + 20), "R3");
  endtask

  task automatic t_wrap;
    cyc(1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd1, "R2");
    cyc(1'b0, 1'b1, 32'h00010000, 32'h00010000, 6'd2, "R2");
    cyc(1'b0, 1'b1, 32'h80000001, 32'h00000003, 6'd3, "R2");
    cyc(1'b0, 1'b1, 32'h0, 32'hCAFEF00D, 6'd4, "R2");
    drain("R2");
  endtask

  task automatic t_lanes;
    for (int k = 0; k < 4; k++)
      cyc(1'b0, 1'b1, 32'h89ABCDEF, 32'hA5 << (8*k), 6'(k), "R5");
    cyc(1'b0, 1'b1, 32'h89ABCDEF, 32'h01010101, 6'd11, "R5");
    drain("R5");
  endtask

  task automatic t_stream;
    logic [31:0] a;
    logic [31:0] b;
    a = 32'h9E3779B9;
    b = 32'h7F4A7C15;
    for (int i = 0; i < 16; i++) begin
      a = {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]};
      b = b * 32'd1103515245 + 32'd12345;
      cyc(1'b0, 1'b1, a, b, 6'(i * 5 + 3), "R4");
    end
    drain("R4");
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 10; i++)
      cyc(1'b0, (i % 3) != 1, 32'h00F0F0F1 * (i + 1), 32'h33333333 + i, 6'(40 + i), "R3");
    drain("R3");
  endtask

  task automatic t_hold;
    cyc(1'b0, 1'b1, 32'h0000FFFF, 32'h00012345, 6'd0, "R8");
    for (int i = 0; i < 5; i++)
      cyc(1'b0, 1'b0, 32'hFFFFFFFF - i, 32'h77777777 + i, 6'(30 + i), "R8");
  endtask

  task automatic t_midreset;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 32'h1111 * (i + 2), 32'h2222, 6'd7, "R7");
    cyc(1'b1, 1'b1, 32'h5, 32'h6, 6'd8, "R7");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 32'h0, 32'h0, 6'(50 + i), "R7");
    cyc(1'b0, 1'b1, 32'd3, 32'd7, 6'd0, "R7");
    drain("R7");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin mv[k] = 1'b0; mp[k] = '0; end
    repeat (2) @(posedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_lanes();
    t_stream();
    t_gaps();
    t_hold();
    t_midreset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule